// File: doc/BRIEF.md
# Joypad Matrix Select Register

This block is the 8-bit port register through which a CPU scans a small button matrix. Software writes two select bits that decide which group of four button lines is visible. Reads return that group as an active-low nibble, so a pressed button reads as 0. When a further controller is attached through a neighbouring packet receiver, the same port can also show that receiver's controller index.

The visible lines are sampled only when the register is accessed. The register is re-evaluated on every CPU write, every CPU read and every pulse of a separate poll strobe. On each evaluation the block compares the old line nibble with the new one. If any line has dropped from 1 to 0, it raises a one-cycle keypad interrupt request. An optional filter, set by a static input, hides an impossible pair of opposing directions on the read path. The filter does not alter the stored register.

The key vector is active-high: `keys[3:0]` is the lower group and `keys[7:4]` is the upper group. Bit 1 means pressed.

Top module: `joy_select_reg`

## Requirements
- R1: While `rst` is high and after it, the register holds 8'hFF, `rd_data` is 8'hFF and `irq` is 0.
- R2: A write stores `wr_data[5:4]` as the select field, and the stored value then has bits [7:6] at 1. Before the key lines are merged, the line nibble [3:0] is taken as 4'hF, whatever the written low bits were.
- R3: With select 2'b10 the line nibble is the inverse of `keys[7:4]`. With select 2'b01 it is the inverse of `keys[3:0]`.
- R4: With select 2'b00 the line nibble is the inverse of `keys[7:4] | keys[3:0]`.
- R5: With select 2'b11 the line nibble is the inverse of `ctrl_idx`, zero-extended to four bits. No button is shown.
- R6: When `ctrl_idx` is nonzero, every key is treated as released before the group is selected.
- R7: `irq` is high for exactly the cycle after an evaluation in which any line bit went from 1 to 0. On a write, the old nibble is taken as 4'hF. A line rising from 0 to 1 never requests.
- R8: Without a write, read or poll, the register does not change and key changes are not seen.
- R9: When `filter_en` is 1 and the value read has select 2'b10, each line pair [1:0] and [3:2] that reads 2'b00 is returned as 2'b11. Other selects are returned unfiltered.
- R10: When a write and a read occur in the same cycle, the write is applied first. The read returns the value produced by that write.
- R11: `rd_data` is registered. It updates in the cycle after `rd_en` and holds its value at all other times, including after writes and polls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data; bits [5:4] are the select field |
| rd_en | input | 1 | CPU read strobe |
| poll_en | input | 1 | Evaluate the lines without a CPU access |
| keys | input | 8 | Pressed-key vector, active-high, two groups of four |
| ctrl_idx | input | 2 | Controller index from the packet receiver |
| filter_en | input | 1 | Static enable for the opposing-direction filter |
| rd_data | output | 8 | Registered read value |
| irq | output | 1 | One-cycle keypad interrupt request |

## Verification
A select write and a read can land in the same cycle. In that case the read must reflect the new select and the freshly merged keys, not the stale register. The edge detector must also compare against the forced-high nibble rather than the old stored lines. The bench first parks the register on one group with a key held. It then issues a write to the other group together with a read, and checks the read value against the post-write result. In the cycle after that access, it also checks that the interrupt pulse appears.

// File: rtl/joy_pkg.sv
package joy_pkg;

  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_LOW  = 2'b01,
    SEL_HIGH = 2'b10,
    SEL_CTRL = 2'b11
  } joy_sel_e;

endpackage

// File: rtl/joy_key_mux.sv
module joy_key_mux #(
  parameter int NIB_W  = 4,
  parameter int CTRL_W = 2
) (
  input  logic [1:0]         sel,
  input  logic [2*NIB_W-1:0] keys,
  input  logic [CTRL_W-1:0]  ctrl,
  output logic [NIB_W-1:0]   nib
);
  import joy_pkg::*;

  logic [NIB_W-1:0]   ctrl_ext;
  logic [2*NIB_W-1:0] keys_gated;

  generate
    if (CTRL_W >= NIB_W) begin : g_ctrl_trunc
      assign ctrl_ext = ctrl[NIB_W-1:0];
    end else begin : g_ctrl_pad
      assign ctrl_ext = {{(NIB_W-CTRL_W){1'b0}}, ctrl};
    end
  endgenerate

  // R6: another controller in focus hides the local keys
  assign keys_gated = (ctrl != '0) ? '0 : keys;

  always_comb begin
    unique case (joy_sel_e'(sel))
      SEL_CTRL: nib = ctrl_ext;
      SEL_HIGH: nib = keys_gated[2*NIB_W-1:NIB_W];
      SEL_LOW:  nib = keys_gated[NIB_W-1:0];
      default:  nib = keys_gated[2*NIB_W-1:NIB_W] | keys_gated[NIB_W-1:0];
    endcase
  end

endmodule

// File: rtl/joy_dir_filter.sv
module joy_dir_filter #(
  parameter int NIB_W = 4,
  parameter int REG_W = 8
) (
  input  logic             en,
  input  logic [REG_W-1:0] val_i,
  output logic [REG_W-1:0] val_o
);
  import joy_pkg::*;

  localparam int PAIRS = NIB_W / 2;

  logic active;
  assign active = en && (joy_sel_e'(val_i[NIB_W+1:NIB_W]) == SEL_HIGH);

  assign val_o[REG_W-1:2*PAIRS] = val_i[REG_W-1:2*PAIRS];

  generate
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      assign val_o[2*p+1:2*p] = (active && val_i[2*p+1:2*p] == 2'b00)
                                ? 2'b11 : val_i[2*p+1:2*p];
    end
  endgenerate

endmodule

// File: rtl/joy_select_reg.sv
module joy_select_reg #(
  parameter int NIB_W  = 4,
  parameter int CTRL_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [2*NIB_W-1:0] wr_data,
  input  logic               rd_en,
  input  logic               poll_en,
  input  logic [2*NIB_W-1:0] keys,
  input  logic [CTRL_W-1:0]  ctrl_idx,
  input  logic               filter_en,
  output logic [2*NIB_W-1:0] rd_data,
  output logic               irq
);
  localparam int REG_W   = 2 * NIB_W;
  localparam int SEL_LSB = NIB_W;
  localparam logic [REG_W-1:0] LINE_ONES = {{(REG_W-NIB_W){1'b0}}, {NIB_W{1'b1}}};
  localparam logic [REG_W-1:0] HOLD_MASK = ~({{(REG_W-2){1'b0}}, 2'b11} << SEL_LSB);

  logic [REG_W-1:0] joy_q, rd_q, base, nxt, filt;
  logic [NIB_W-1:0] nib;
  logic             irq_q, ev, fell;

  assign ev   = wr_en | rd_en | poll_en;
  // R2/R10: a write supplies the select and forces the lines high first
  assign base = wr_en ? (wr_data | LINE_ONES) : joy_q;

  joy_key_mux #(.NIB_W(NIB_W), .CTRL_W(CTRL_W)) mux_i (
    .sel  (base[SEL_LSB+1:SEL_LSB]),
    .keys (keys),
    .ctrl (ctrl_idx),
    .nib  (nib)
  );

  assign nxt  = (HOLD_MASK | base) ^ {{(REG_W-NIB_W){1'b0}}, nib};
  assign fell = |(base[NIB_W-1:0] & ~nxt[NIB_W-1:0]);

  joy_dir_filter #(.NIB_W(NIB_W), .REG_W(REG_W)) filt_i (
    .en    (filter_en),
    .val_i (nxt),
    .val_o (filt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      joy_q <= '1;
      rd_q  <= '1;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ev & fell;
      if (ev)    joy_q <= nxt;
      if (rd_en) rd_q  <= filt;
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  assert_upper_ones_R2: assert property (@(posedge clk) disable iff (rst)
    (&rd_data[REG_W-1:SEL_LSB+2]) && (&joy_q[REG_W-1:SEL_LSB+2]));

  assert_sel_stored_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> joy_q[SEL_LSB+1:SEL_LSB] == $past(wr_data[SEL_LSB+1:SEL_LSB]));

  assert_ctrl_view_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && joy_q[SEL_LSB+1:SEL_LSB] == 2'b11 && ctrl_idx == '0)
      |=> rd_data[NIB_W-1:0] == {NIB_W{1'b1}});

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ev));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ev |=> $stable(joy_q));

  assert_no_opposed_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && filter_en) |=>
      (rd_data[SEL_LSB+1:SEL_LSB] != 2'b10 ||
       (rd_data[1:0] != 2'b00 && rd_data[3:2] != 2'b00)));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/joy_select_reg_tb.sv
`timescale 1ns/1ps
module joy_select_reg_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, poll_en = 1'b0, filter_en = 1'b0;
  logic [7:0] wr_data = '0, keys = '0;
  logic [1:0] ctrl_idx = '0;
  logic [7:0] rd_data;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  joy_select_reg dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .poll_en(poll_en), .keys(keys), .ctrl_idx(ctrl_idx), .filter_en(filter_en),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one access cycle; returns at the negedge after the capturing edge
  task automatic access(input bit w, input logic [7:0] d, input bit r, input bit p);
    @(negedge clk);
    wr_en = w; wr_data = d; rd_en = r; poll_en = p;
    @(negedge clk);
    wr_en = 0; rd_en = 0; poll_en = 0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 8'hFF);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    access(0, 0, 1, 0);
    chk("R1 reg read", rd_data, 8'hFF);
  endtask

  task automatic t_write;
    keys = 8'h00;
    access(1, 8'h20, 0, 0);
    chk("R11 no update on write", rd_data, 8'hFF);
    access(0, 0, 1, 0);
    chk("R2 sel 10 stored", rd_data, 8'hEF);
    access(1, 8'h00, 1, 0);
    chk("R2 upper bits one", rd_data, 8'hCF);
  endtask

  task automatic t_groups;
    keys = 8'h50;
    access(1, 8'h20, 0, 0);
    chk("R7 irq on write", {7'd0, irq}, 8'h01);
    access(0, 0, 1, 0);
    chk("R3 upper group", rd_data, 8'hEA);
    chk("R7 no irq steady", {7'd0, irq}, 8'h00);
    keys = 8'h03;
    access(1, 8'h10, 1, 0);
    chk("R3 lower group", rd_data, 8'hDC);
    keys = 8'h12;
    access(1, 8'h00, 1, 0);
    chk("R4 both groups", rd_data, 8'hCC);
  endtask

  task automatic t_ctrl;
    ctrl_idx = 2'd2; keys = 8'h0F;
    access(1, 8'h30, 1, 0);
    chk("R5 ctrl index", rd_data, 8'hFD);
    access(1, 8'h10, 1, 0);
    chk("R6 keys masked", rd_data, 8'hDF);
    ctrl_idx = 2'd0;
    access(0, 0, 1, 0);
    chk("R6 keys visible idx0", rd_data, 8'hD0);
    access(1, 8'h10, 0, 0);
    chk("R7 write vs forced F", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_poll;
    keys = 8'h00;
    access(1, 8'h10, 1, 0);
    chk("R7 rise no irq", {7'd0, irq}, 8'h00);
    keys = 8'h01;
    repeat (3) @(negedge clk);
    chk("R8 idle no irq", {7'd0, irq}, 8'h00);
    chk("R8 idle rd hold", rd_data, 8'hDF);
    access(0, 0, 0, 1);
    chk("R7 poll irq", {7'd0, irq}, 8'h01);
    chk("R11 poll keeps rd", rd_data, 8'hDF);
    @(negedge clk);
    chk("R7 one cycle", {7'd0, irq}, 8'h00);
    access(0, 0, 1, 0);
    chk("R8 read sees key", rd_data, 8'hDE);
  endtask

  task automatic t_filter;
    filter_en = 1; keys = 8'hF0;
    access(1, 8'h20, 1, 0);
    chk("R9 both pairs forced", rd_data, 8'hEF);
    keys = 8'h50;
    access(0, 0, 1, 0);
    chk("R9 no force", rd_data, 8'hEA);
    keys = 8'h30;
    access(0, 0, 1, 0);
    chk("R9 one pair forced", rd_data, 8'hEF);
    keys = 8'h0F;
    access(1, 8'h10, 1, 0);
    chk("R9 other select", rd_data, 8'hD0);
    filter_en = 0; keys = 8'hF0;
    access(1, 8'h20, 1, 0);
    chk("R9 filter off", rd_data, 8'hE0);
  endtask

  task automatic t_same_cycle;
    keys = 8'h21;
    access(1, 8'h10, 0, 0);
    access(1, 8'h20, 1, 0);
    chk("R10 write then read", rd_data, 8'hED);
    chk("R10 irq same access", {7'd0, irq}, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", rd_data, 8'hFF);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write();
    t_groups();
    t_ctrl();
    t_poll();
    t_filter();
    t_same_cycle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule